// File: doc/BRIEF.md
# Open-Wire Fault Debouncer

This block turns raw per-cell "input below the open-wire threshold" flags into a qualified open-wire fault. A monitoring front end presents one sample per monitoring cycle, marked by a one-clock strobe. The block holds the fault only after a programmable run of agreeing samples. Clearing the fault needs the same run length of clean samples. A single sample that disagrees with the run in progress restarts that run, in either direction. The qualified fault is ORed with an external overvoltage fault. The result then passes through a polarity control to form a single registered alarm output.

Cell positions that the pack does not populate are masked, so their flags can never raise a fault. The number of populated cells is given at run time. The unused positions are the lowest-indexed ones. A quick test input collapses every run length to a single sample for fast board-level checking.

Top module: `ow_qualifier`

## Requirements
- R1: With an effective delay of N, the fault (`open_fault`) rises after the strobe of the (N+1)-th consecutive sample in which at least one active cell flag is 1. It is readable at the port one clock after that strobe edge.
- R2: While the fault is clear, a sample in which every active flag is 0 resets the detection run, so N+1 fresh low samples are needed afterwards.
- R3: While the fault is set, it clears after the (N+1)-th consecutive sample in which every active flag is 0.
- R4: While the fault is set, a sample with any active flag at 1 resets the release run, so N+1 fresh clean samples are needed afterwards.
- R5: The effective delay N equals `delay_set` for values 0 to 14. Any larger `delay_set` value acts as 14.
- R6: With `quick_mode` at 1, the effective delay is 0, so one sample both detects and releases.
- R7: With `active_cnt` = k (k ≤ number of cells), only flag indices at or above (cells − k) take part. A value above the number of cells enables every position.
- R8: Without the sample strobe, neither the fault nor the run count changes, whatever the flags do.
- R9: `alarm` equals (`open_fault` OR `ov_fault`) XOR `alarm_invert`, registered one clock later.
- R10: Synchronous reset clears the fault, the run count and `alarm`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid | input | 1 | One-clock strobe: a new monitoring sample is present |
| cell_low | input | NCELL | Per-cell flag, 1 = input below the open-wire threshold |
| active_cnt | input | CW | Number of populated cells (upper positions) |
| delay_set | input | DW | Debounce delay setting N |
| quick_mode | input | 1 | 1 = single-sample qualification |
| ov_fault | input | 1 | Overvoltage fault from the neighbouring block |
| alarm_invert | input | 1 | 1 = active-high alarm level inverted |
| open_fault | output | 1 | Qualified open-wire fault |
| alarm | output | 1 | Combined, polarity-adjusted, registered alarm |

## Verification
Every delay setting from 0 to 15 is swept with quick mode off and on. For each, the input runs stop one sample short of the limit before a contrary sample is inserted. The fault must not appear at N samples. It must appear only after N+1 fresh samples, which separates an off-by-one limit from a run that is not restarted. The release direction gets the same pattern, which tells whether the restart works in both directions. Masked-position patterns, strobe-free flag toggling and all combinations of overvoltage and inversion separate masking, hold and alarm-combination faults from the debounce path.

// File: rtl/owq_pkg.sv
package owq_pkg;
  typedef enum logic {
    ST_NORMAL = 1'b0,
    ST_OPEN   = 1'b1
  } owq_state_t;
endpackage

// File: rtl/owq_cell_mask.sv
module owq_cell_mask #(
  parameter int NCELL = 5,
  parameter int CW    = $clog2(NCELL + 1)
) (
  input  logic [NCELL-1:0] cell_low,
  input  logic [CW-1:0]    active_cnt,
  output logic             any_low
);
  logic [CW-1:0]    act_sat;
  logic [NCELL-1:0] keep;

  always_comb begin
    act_sat = (32'(active_cnt) > NCELL) ? CW'(NCELL) : active_cnt;
  end

  // Populated cells occupy the upper positions; lower ones are forced clean
  for (genvar gi = 0; gi < NCELL; gi++) begin : g_keep
    assign keep[gi] = (32'(act_sat) >= (NCELL - gi));
  end

  assign any_low = |(cell_low & keep);
endmodule

// File: rtl/owq_debounce.sv
module owq_debounce
  import owq_pkg::*;
#(
  parameter int DW   = 4,
  parameter int MAXD = 14,
  parameter int KW   = $clog2(MAXD + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sample_valid,
  input  logic          any_low,
  input  logic [DW-1:0] delay_set,
  input  logic          quick_mode,
  output logic          open_fault
);
  owq_state_t    state;
  logic [KW-1:0] run_cnt;
  logic [DW-1:0] d_sat;
  logic [KW-1:0] lim;
  logic          agree;

  always_comb begin
    d_sat = (32'(delay_set) > MAXD) ? DW'(MAXD) : delay_set;
    lim   = quick_mode ? '0 : KW'(d_sat);
    agree = (state == ST_NORMAL) ? any_low : !any_low;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_NORMAL;
      run_cnt <= '0;
    end else if (sample_valid) begin
      if (agree) begin
        if (run_cnt == lim) begin
          state   <= (state == ST_NORMAL) ? ST_OPEN : ST_NORMAL;
          run_cnt <= '0;
        end else begin
          run_cnt <= run_cnt + KW'(1);
        end
      end else begin
        run_cnt <= '0;
      end
    end
  end

  assign open_fault = (state == ST_OPEN);

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !sample_valid |=> ($stable(open_fault) && $stable(run_cnt)));
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
    32'(run_cnt) <= MAXD);
  p_clean_restart_r2: assert property (@(posedge clk) disable iff (rst)
    (sample_valid && !any_low && !open_fault) |=> (!open_fault && run_cnt == '0));
  p_low_restart_r4: assert property (@(posedge clk) disable iff (rst)
    (sample_valid && any_low && open_fault) |=> (open_fault && run_cnt == '0));
  p_rise_cause_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(open_fault) |-> $past(sample_valid && any_low));
  p_quick_det_r6: assert property (@(posedge clk) disable iff (rst)
    (sample_valid && quick_mode && any_low && !open_fault) |=> open_fault);
  p_quick_rel_r6: assert property (@(posedge clk) disable iff (rst)
    (sample_valid && quick_mode && !any_low && open_fault) |=> !open_fault);
endmodule

// File: rtl/owq_alarm_drive.sv
module owq_alarm_drive (
  input  logic clk,
  input  logic rst,
  input  logic wire_fault,
  input  logic volt_fault,
  input  logic invert,
  output logic alarm
);
  always_ff @(posedge clk) begin
    if (rst) alarm <= 1'b0;
    else     alarm <= (wire_fault | volt_fault) ^ invert;
  end

  p_alarm_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (!wire_fault && !volt_fault && !invert) |=> !alarm);
endmodule

// File: rtl/ow_qualifier.sv
module ow_qualifier #(
  parameter int NCELL = 5,
  parameter int CW    = $clog2(NCELL + 1),
  parameter int DW    = 4,
  parameter int MAXD  = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sample_valid,
  input  logic [NCELL-1:0] cell_low,
  input  logic [CW-1:0]    active_cnt,
  input  logic [DW-1:0]    delay_set,
  input  logic             quick_mode,
  input  logic             ov_fault,
  input  logic             alarm_invert,
  output logic             open_fault,
  output logic             alarm
);
  logic any_low;

  owq_cell_mask #(.NCELL(NCELL), .CW(CW)) u_mask (
    .cell_low   (cell_low),
    .active_cnt (active_cnt),
    .any_low    (any_low)
  );

  owq_debounce #(.DW(DW), .MAXD(MAXD)) u_deb (
    .clk          (clk),
    .rst          (rst),
    .sample_valid (sample_valid),
    .any_low      (any_low),
    .delay_set    (delay_set),
    .quick_mode   (quick_mode),
    .open_fault   (open_fault)
  );

  owq_alarm_drive u_alarm (
    .clk        (clk),
    .rst        (rst),
    .wire_fault (open_fault),
    .volt_fault (ov_fault),
    .invert     (alarm_invert),
    .alarm      (alarm)
  );

  p_reset_r10: assert property (@(posedge clk) rst |=> (!open_fault && !alarm));
endmodule

// File: tb/sim_ow_qualifier.sv
module sim_ow_qualifier;
  localparam int NCELL = 5;
  localparam int CW    = 3;
  localparam int DW    = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             sample_valid = 1'b0;
  logic [NCELL-1:0] cell_low = '0;
  logic [CW-1:0]    active_cnt = 3'd5;
  logic [DW-1:0]    delay_set = '0;
  logic             quick_mode = 1'b0;
  logic             ov_fault = 1'b0;
  logic             alarm_invert = 1'b0;
  logic             open_fault;
  logic             alarm;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ow_qualifier #(.NCELL(NCELL), .DW(DW)) u0 (.*);

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    sample_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // One strobed sample; returns at the negedge after the updating edge
  task automatic smp(input logic [NCELL-1:0] low);
    @(negedge clk);
    cell_low = low;
    sample_valid = 1'b1;
    @(negedge clk);
    sample_valid = 1'b0;
  endtask

  task automatic run_low(input int n);
    for (int k = 0; k < n; k++) smp(NCELL'(1) << (k % NCELL));
  endtask

  task automatic run_clean(input int n);
    for (int k = 0; k < n; k++) smp('0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    @(negedge clk);
    chk("R10 fault after reset", open_fault, 1'b0);
    chk("R10 alarm after reset", alarm, 1'b0);

    // Sweep all delay codes, quick mode off and on
    for (int d = 0; d < 16; d++) begin
      for (int q = 0; q < 2; q++) begin
        int lim;
        lim = (q != 0) ? 0 : ((d > 14) ? 14 : d);
        do_reset();
        active_cnt = 3'd5;
        delay_set = DW'(d);
        quick_mode = q[0];
        run_low(lim);
        chk("R1/R5/R6 no fault at N low samples", open_fault, 1'b0);
        smp('0);
        chk("R2 clean sample keeps fault clear", open_fault, 1'b0);
        run_low(lim);
        chk("R2 restarted run not done at N", open_fault, 1'b0);
        run_low(1);
        chk("R1/R5/R6 fault at N+1 low samples", open_fault, 1'b1);
        run_clean(lim);
        chk("R3 fault held at N clean samples", open_fault, 1'b1);
        smp(5'b10000);
        chk("R4 low sample keeps fault", open_fault, 1'b1);
        run_clean(lim);
        chk("R4 restarted release not done at N", open_fault, 1'b1);
        run_clean(1);
        chk("R3 fault clears at N+1 clean samples", open_fault, 1'b0);
      end
    end

    // R8: flags toggle without strobe
    do_reset();
    delay_set = 4'd0;
    quick_mode = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      cell_low = 5'b11111;
    end
    @(negedge clk);
    chk("R8 no strobe no detect", open_fault, 1'b0);
    smp(5'b00001);
    chk("R8 strobe then detects", open_fault, 1'b1);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      cell_low = 5'b00000;
    end
    @(negedge clk);
    chk("R8 no strobe no release", open_fault, 1'b1);

    // R7: masking of unused low positions, delay 0
    do_reset();
    active_cnt = 3'd3;
    smp(5'b00011);
    chk("R7 unused positions ignored (k=3)", open_fault, 1'b0);
    smp(5'b00100);
    chk("R7 lowest active position used (k=3)", open_fault, 1'b1);
    smp(5'b00011);
    chk("R7 unused positions do not block release", open_fault, 1'b0);
    active_cnt = 3'd1;
    smp(5'b01111);
    chk("R7 only top position active (k=1)", open_fault, 1'b0);
    active_cnt = 3'd7;
    smp(5'b00001);
    chk("R7 oversize count enables all", open_fault, 1'b1);

    // R9: alarm combination and polarity
    for (int f = 0; f < 2; f++) begin
      do_reset();
      active_cnt = 3'd5;
      delay_set = 4'd0;
      if (f != 0) smp(5'b00001);
      for (int o = 0; o < 2; o++) begin
        for (int i = 0; i < 2; i++) begin
          @(negedge clk);
          ov_fault = o[0];
          alarm_invert = i[0];
          @(negedge clk);
          chk("R9 alarm combination", alarm, (f[0] | o[0]) ^ i[0]);
        end
      end
      ov_fault = 1'b0;
      alarm_invert = 1'b0;
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule